// File: doc/BRIEF.md
# Line-Based Pixel Cluster Finder

This block takes one line of binary pixel hits from a group of 64 adjacent columns, one bit per pixel, where a set bit means that pixel's comparator fired. It packs the fired pixels into a short list of windows. Each window is 4 pixels wide and is described by a start column and a 4-bit hit pattern. The list replaces per-pixel addresses for the stage that reads it next, and at most 6 windows are kept for each line.

A line is presented with a one-cycle valid strobe, together with its row number. On the next cycle the block pulses a done flag, and it holds the window list, the row number and an overflow flag stable until the next strobe arrives. The scan is greedy and starts from the lowest column. When a seventh window would be needed, the overflow flag is raised and the remaining hits are dropped.

Top module: `line_cluster_finder`

## Requirements
- R1: After reset, and until the first strobe is registered, every output is 0.
- R2: A strobe on `line_valid` at a rising edge makes `result_done` high for the cycle that follows that edge, with `result_row` equal to the row presented with the strobe. `result_done` is low in any cycle not preceded by a strobe.
- R3: Bit c of `line_pixels` is column c. Windows are formed from column 0 upward. A window starts at the lowest fired column not covered by an earlier window of the same line, and it covers that column and the next 3 columns.
- R4: Slot pattern bit k is the pixel at start column plus k, so bit 0 (the start column) is always 1 in a valid slot.
- R5: A window that starts above column 60 is truncated, and its pattern bits for columns beyond 63 are 0.
- R6: Window n in scan order goes to slot n. Slot i uses bits [6i+5:6i] of `slot_col` and bits [4i+3:4i] of `slot_pat`. The valid bits are filled from slot 0 with no gaps, and an unused slot has column 0 and pattern 0.
- R7: When the line needs more than 6 windows, the first 6 are reported, all 6 slots are valid, and `result_overflow` is 1. Otherwise `result_overflow` is 0.
- R8: A line with no fired pixel gives no valid slot and no overflow.
- R9: While `line_valid` is low, every result output keeps its value, whatever `line_pixels` and `line_row` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | One-cycle strobe: pixels and row are valid |
| line_row | input | 10 | Row number of the presented line |
| line_pixels | input | 64 | Discriminated hits, bit c = column c |
| result_done | output | 1 | One-cycle pulse when new results are shown |
| result_row | output | 10 | Row number of the held results |
| result_overflow | output | 1 | More than 6 windows were needed |
| slot_valid | output | 6 | Valid bit per slot |
| slot_col | output | 36 | Start column per slot, 6 bits each |
| slot_pat | output | 24 | Hit pattern per slot, 4 bits each |

## Verification
A wrong skip count in the scan shows up on the first line that has two hits less than 4 columns apart: a window is split in two, or a hit is swallowed, and both the start columns and the slot count change in the cycle right after the strobe. A wrong slot counter shows up as a gap in the valid bits or as an early overflow on any line with several windows. A faulty hold path appears one cycle after the strobe, because the bench changes the pixel and row inputs between strobes and compares the outputs again. Directed lines cover column 63, lines that need exactly 6 and 7 windows, and empty and full lines. Sparse and dense random lines cover the other cases.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
    localparam int LCF_COLS  = 64;
    localparam int LCF_WIN   = 4;
    localparam int LCF_SLOTS = 6;
    localparam int LCF_ROW_W = 10;
endpackage

// File: rtl/lcf_window_scan.sv
module lcf_window_scan #(
    parameter int NCOLS = lcf_pkg::LCF_COLS,
    parameter int WIN   = lcf_pkg::LCF_WIN,
    parameter int SLOTS = lcf_pkg::LCF_SLOTS,
    localparam int COL_W = $clog2(NCOLS)
) (
    input  logic [NCOLS-1:0]       pix,
    output logic [SLOTS-1:0]       win_valid,
    output logic [SLOTS*COL_W-1:0] win_col,
    output logic [SLOTS*WIN-1:0]   win_pat,
    output logic                   win_ovf
);
    // Greedy lowest-first scan; skip counts columns still covered.
    always_comb begin
        int skip;
        int n;
        skip      = 0;
        n         = 0;
        win_valid = '0;
        win_col   = '0;
        win_pat   = '0;
        win_ovf   = 1'b0;
        for (int c = 0; c < NCOLS; c++) begin
            if (skip > 0) begin
                skip = skip - 1;
            end else if (pix[c]) begin
                if (n < SLOTS) begin
                    win_valid[n] = 1'b1;
                    win_col[n*COL_W +: COL_W] = COL_W'(c);
                    for (int k = 0; k < WIN; k++) begin
                        if (c + k < NCOLS) begin
                            win_pat[n*WIN + k] = pix[c + k];
                        end
                    end
                    n = n + 1;
                end else begin
                    win_ovf = 1'b1;
                end
                skip = WIN - 1;
            end
        end
    end
endmodule

// File: rtl/lcf_result_reg.sv
module lcf_result_reg #(
    parameter int COL_W = 6,
    parameter int WIN   = 4,
    parameter int SLOTS = 6,
    parameter int ROW_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [ROW_W-1:0]       row_in,
    input  logic                   ovf_in,
    input  logic [SLOTS-1:0]       valid_in,
    input  logic [SLOTS*COL_W-1:0] col_in,
    input  logic [SLOTS*WIN-1:0]   pat_in,
    output logic                   done,
    output logic [ROW_W-1:0]       row_out,
    output logic                   ovf_out,
    output logic [SLOTS-1:0]       valid_out,
    output logic [SLOTS*COL_W-1:0] col_out,
    output logic [SLOTS*WIN-1:0]   pat_out
);
    typedef struct packed {
        logic                   done;
        logic                   ovf;
        logic [ROW_W-1:0]       row;
        logic [SLOTS-1:0]       valid;
        logic [SLOTS*COL_W-1:0] col;
        logic [SLOTS*WIN-1:0]   pat;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d      = res_q;
        res_d.done = load;
        if (load) begin
            res_d.ovf   = ovf_in;
            res_d.row   = row_in;
            res_d.valid = valid_in;
            res_d.col   = col_in;
            res_d.pat   = pat_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done      = res_q.done;
    assign row_out   = res_q.row;
    assign ovf_out   = res_q.ovf;
    assign valid_out = res_q.valid;
    assign col_out   = res_q.col;
    assign pat_out   = res_q.pat;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> done);
    // R2
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !done);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(valid_out) && $stable(col_out) && $stable(pat_out)
                   && $stable(ovf_out) && $stable(row_out)));
    // R7
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_out |-> (&valid_out));
    // R6
    contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_out + 1'b1) & valid_out) == '0);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot_chk
        // R4
        start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out[i] |-> pat_out[i*WIN]);
        // R6
        empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_out[i] |-> (col_out[i*COL_W +: COL_W] == '0 && pat_out[i*WIN +: WIN] == '0));
        if (i + 1 < SLOTS) begin : g_order
            // R3
            spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_out[i+1] |-> (int'(col_out[(i+1)*COL_W +: COL_W])
                                    >= int'(col_out[i*COL_W +: COL_W]) + WIN));
        end
    end
endmodule

// File: rtl/line_cluster_finder.sv
module line_cluster_finder #(
    parameter int NCOLS = lcf_pkg::LCF_COLS,
    parameter int WIN   = lcf_pkg::LCF_WIN,
    parameter int SLOTS = lcf_pkg::LCF_SLOTS,
    parameter int ROW_W = lcf_pkg::LCF_ROW_W,
    localparam int COL_W = $clog2(NCOLS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_valid,
    input  logic [ROW_W-1:0]       line_row,
    input  logic [NCOLS-1:0]       line_pixels,
    output logic                   result_done,
    output logic [ROW_W-1:0]       result_row,
    output logic                   result_overflow,
    output logic [SLOTS-1:0]       slot_valid,
    output logic [SLOTS*COL_W-1:0] slot_col,
    output logic [SLOTS*WIN-1:0]   slot_pat
);
    logic [SLOTS-1:0]       scan_valid;
    logic [SLOTS*COL_W-1:0] scan_col;
    logic [SLOTS*WIN-1:0]   scan_pat;
    logic                   scan_ovf;

    lcf_window_scan #(.NCOLS(NCOLS), .WIN(WIN), .SLOTS(SLOTS)) scan_i (
        .pix       (line_pixels),
        .win_valid (scan_valid),
        .win_col   (scan_col),
        .win_pat   (scan_pat),
        .win_ovf   (scan_ovf)
    );

    lcf_result_reg #(.COL_W(COL_W), .WIN(WIN), .SLOTS(SLOTS), .ROW_W(ROW_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (line_valid),
        .row_in    (line_row),
        .ovf_in    (scan_ovf),
        .valid_in  (scan_valid),
        .col_in    (scan_col),
        .pat_in    (scan_pat),
        .done      (result_done),
        .row_out   (result_row),
        .ovf_out   (result_overflow),
        .valid_out (slot_valid),
        .col_out   (slot_col),
        .pat_out   (slot_pat)
    );
endmodule

// File: tb/line_cluster_finder_tb.sv
module line_cluster_finder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 64;
    localparam int W  = 4;
    localparam int S  = 6;
    localparam int CW = 6;
    localparam int RW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            line_valid = 1'b0;
    logic [RW-1:0]   line_row = '0;
    logic [NC-1:0]   line_pixels = '0;
    logic            result_done;
    logic [RW-1:0]   result_row;
    logic            result_overflow;
    logic [S-1:0]    slot_valid;
    logic [S*CW-1:0] slot_col;
    logic [S*W-1:0]  slot_pat;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_cluster_finder dut_i (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_row(line_row),
        .line_pixels(line_pixels), .result_done(result_done), .result_row(result_row),
        .result_overflow(result_overflow), .slot_valid(slot_valid),
        .slot_col(slot_col), .slot_pat(slot_pat)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected windows, written from R3..R8.
    task automatic model(input logic [NC-1:0] p, output logic [S-1:0] v,
                         output logic [S*CW-1:0] c, output logic [S*W-1:0] pt,
                         output logic ov);
        int col;
        int n;
        v = '0; c = '0; pt = '0; ov = 1'b0; col = 0; n = 0;
        while (col < NC) begin
            if (p[col]) begin
                if (n == S) ov = 1'b1;
                else begin
                    v[n] = 1'b1;
                    c[n*CW +: CW] = CW'(col);
                    for (int k = 0; k < W; k++)
                        if (col + k < NC) pt[n*W + k] = p[col + k];
                    n++;
                end
                col += W;
            end else col++;
        end
    endtask

    task automatic run_line(input logic [NC-1:0] p, input logic [RW-1:0] r, input string tag);
        logic [S-1:0] ev; logic [S*CW-1:0] ec; logic [S*W-1:0] ep; logic eo;
        model(p, ev, ec, ep, eo);
        @(negedge clk);
        line_pixels = p; line_row = r; line_valid = 1'b1;
        @(negedge clk);
        line_valid = 1'b0;
        chk({"R2 done ", tag}, 64'(result_done), 64'd1);
        chk({"R2 row ", tag}, 64'(result_row), 64'(r));
        chk({"R7 overflow ", tag}, 64'(result_overflow), 64'(eo));
        chk({"R6 valid ", tag}, 64'(slot_valid), 64'(ev));
        chk({"R3 col ", tag}, 64'(slot_col), 64'(ec));
        chk({"R4 pat ", tag}, 64'(slot_pat), 64'(ep));
        line_pixels = ~p; line_row = ~r;
        @(negedge clk);
        chk({"R2 done low ", tag}, 64'(result_done), 64'd0);
        chk({"R9 hold valid ", tag}, 64'(slot_valid), 64'(ev));
        chk({"R9 hold col ", tag}, 64'(slot_col), 64'(ec));
        chk({"R9 hold pat/ovf ", tag}, 64'({slot_pat, result_overflow}), 64'({ep, eo}));
        chk({"R9 hold row ", tag}, 64'(result_row), 64'(r));
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] p;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", 64'({result_done, result_overflow, slot_valid}), 64'd0);
        chk("R1 reset fields", 64'(slot_col) | 64'(slot_pat) | 64'(result_row), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'({result_done, result_overflow, slot_valid}), 64'd0);

        run_line(64'd0, 10'd1, "R8 empty");
        chk("R8 empty no ovf", 64'({result_overflow, slot_valid}), 64'd0);
        run_line(64'h8000_0000_0000_0000, 10'd2, "R5 col63");
        run_line(64'hA000_0000_0000_0000, 10'd3, "R5 col61+63");
        run_line(64'h0000_0000_0000_0009, 10'd4, "R3 span 0..3");
        run_line(64'h0000_0000_0000_0011, 10'd5, "R3 split 0,4");
        run_line(64'h0000_0000_0111_1111 & 64'h0000_0000_0011_1111, 10'd6, "R7 six");
        run_line(64'h0000_0000_0111_1111, 10'd7, "R7 seven");
        run_line('1, 10'd8, "R7 full");
        run_line(64'h0000_0000_0000_0000 | (64'd1 << 62), 10'd9, "R5 col62");
        for (int i = 0; i < 150; i++) begin
            p = '0;
            for (int b = 0; b < NC; b++)
                p[b] = (($urandom % ((i % 3 == 0) ? 2 : 12)) == 0);
            run_line(p, RW'($urandom), "R3 random");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule